// File: doc/BRIEF.md
# Paged Non-Volatile Byte Store Controller

This controller sits behind a single-beat register access port. It serves two address regions. One is a bank of volatile byte registers in the low address range. The other is a behavioural non-volatile array of 1024 bytes, placed in a high window. A byte in the array can be programmed only while it still holds the erased value FFh. To return a byte to FFh, its whole 32-byte page must be erased. An erase is started by command byte FEh, and only while an enable bit in a volatile configuration register is set.

After each reset, the controller copies the first `BOOT_LEN` bytes of the array into the matching volatile registers. The access port rejects every request until that copy is finished. Programming and erasing each keep the block busy for a fixed number of cycles, and any access made while busy is rejected. A sticky error flag records each write or command that was refused. The array holds its contents across reset, so a later reset loads whatever was programmed before it.

Top module: `nvm_page_ctrl`

## Requirements
- R1: Volatile registers answer at addresses 0000h–00DFh with single-byte reads and writes. Any other address outside the array window reads 00h, and a write to it changes nothing.
- R2: The array answers at F800h–FBFFh with single-byte reads. A byte that has never been programmed reads FFh.
- R3: A write to the array lands only when the target byte reads FFh. Otherwise the byte keeps its value and err_o is set.
- R4: A command (op_i = 2) carrying FEh sets all 32 bytes of one page to FFh and leaves every other page untouched. The page is address bits [9:5] of the most recent accepted array read or write.
- R5: The erase command takes effect only when bit 2 of the volatile register at 0090h is 1. When that bit is 0, the command is ignored, no busy period starts, and err_o does not change.
- R6: A command with any byte other than FEh is ignored.
- R7: After reset release, array bytes 0 to BOOT_LEN-1 are copied into volatile registers 0 to BOOT_LEN-1, one byte per cycle. ready_o stays low during the copy and rises after exactly BOOT_LEN clock edges. Array contents survive reset.
- R8: While ready_o is low, every request is rejected. Reads return 00h, writes do not land, and a rejected write sets err_o.
- R9: An accepted program holds busy_o for PROG_CYC cycles and an erase for ERASE_CYC cycles. Requests made during busy are rejected: reads return 00h, and writes and commands have no effect and set err_o.
- R10: Every request gets ack_o one cycle later. Write, command, rejected and unmapped accesses return rdata_o = 00h.
- R11: err_o is 0 after reset and, once set, stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per beat |
| op_i | input | 2 | 0 read, 1 write, 2 command, 3 reserved (ignored) |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data or command byte |
| ack_o | output | 1 | Response strobe, one cycle after req_i |
| rdata_o | output | 8 | Read data valid with ack_o |
| busy_o | output | 1 | Program or erase in progress |
| ready_o | output | 1 | Boot copy finished |
| err_o | output | 1 | Sticky rejected-write flag |

## Verification
The bench rewrites a programmed byte and expects the old value to remain with err_o set. A design that skips the erased check would return the new value instead. It issues FEh with the enable bit clear and also sends a non-erase command code. A design with a loose gate would wipe page 0 or raise busy_o in either case. A real erase is run with a programmed byte left in page 1, which catches a wrong page select or an erase that spreads across the array. Back-to-back requests during busy and during the boot copy must read 00h and leave the array unchanged. A second reset then has to reload the bytes programmed earlier, which exposes a copy that is off by one or an array cleared by reset.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_CMD = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_NV   = 2'd2
  } rgn_e;

  localparam logic [7:0] ERASED_BYTE   = 8'hFF;
  localparam logic [7:0] CMD_PAGE_ERASE = 8'hFE;
  localparam int unsigned CFG_REG_IDX  = 'h90;
  localparam int unsigned CFG_ERASE_EN = 2;
endpackage

// File: rtl/nvm_addr_dec.sv
module nvm_addr_dec
  import nvm_pkg::*;
#(
  parameter int unsigned NV_BASE   = 'hF800,
  parameter int unsigned NV_BYTES  = 1024,
  parameter int unsigned RAM_BYTES = 224,
  parameter int unsigned NV_AW     = 10,
  parameter int unsigned RAM_AW    = 8
) (
  input  logic [15:0]       addr_i,
  output rgn_e              rgn_o,
  output logic [NV_AW-1:0]  nv_off_o,
  output logic [RAM_AW-1:0] ram_idx_o
);
  logic [15:0] nv_rel;

  assign nv_rel    = addr_i - 16'(NV_BASE);
  assign nv_off_o  = NV_AW'(nv_rel);
  assign ram_idx_o = RAM_AW'(addr_i);

  always_comb begin
    rgn_o = RGN_NONE;
    if (32'(addr_i) < RAM_BYTES)
      rgn_o = RGN_RAM;
    else if (32'(addr_i) >= NV_BASE && 32'(addr_i) < NV_BASE + NV_BYTES)
      rgn_o = RGN_NV;
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int unsigned PAGES      = 32,
  parameter int unsigned PAGE_BYTES = 32,
  localparam int unsigned NV_BYTES  = PAGES * PAGE_BYTES,
  localparam int unsigned NV_AW     = $clog2(NV_BYTES),
  localparam int unsigned PG_W      = $clog2(PAGES),
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_en_i,
  input  logic [NV_AW-1:0] prog_addr_i,
  input  logic [7:0]       prog_data_i,
  input  logic             erase_en_i,
  input  logic [PG_W-1:0]  erase_page_i,
  input  logic [NV_AW-1:0] rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic [NV_AW-1:0] boot_addr_i,
  output logic [7:0]       boot_data_o
);
  // behavioural storage: not reset, contents persist across rst_ni
  logic [7:0] mem [NV_BYTES];

  initial begin
    for (int i = 0; i < NV_BYTES; i++) mem[i] = ERASED_BYTE;
  end

  always_ff @(posedge clk_i) begin
    if (erase_en_i) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        mem[{erase_page_i, OFF_W'(j)}] <= ERASED_BYTE;
    end else if (prog_en_i) begin
      mem[prog_addr_i] <= prog_data_i;
    end
  end

  assign rd_data_o   = mem[rd_addr_i];
  assign boot_data_o = mem[boot_addr_i];

  a_r3_prog_only_erased: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |-> mem[prog_addr_i] == ERASED_BYTE);
  a_r4_page_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_i |=> mem[{$past(erase_page_i), OFF_W'(0)}] == ERASED_BYTE
                && mem[{$past(erase_page_i), {OFF_W{1'b1}}}] == ERASED_BYTE);
  a_r4_excl_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_en_i && prog_en_i));
endmodule

// File: rtl/nvm_busy_tmr.sv
module nvm_busy_tmr #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;

  a_r9_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0);
  a_r9_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/nvm_boot_seq.sv
module nvm_boot_seq #(
  parameter int unsigned BOOT_LEN = 8,
  localparam int unsigned BW = $clog2(BOOT_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          copy_o,
  output logic [BW-1:0] idx_o,
  output logic          ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      if (idx_o == BW'(BOOT_LEN - 1)) ready_o <= 1'b1;
      else                            idx_o   <= idx_o + 1'b1;
    end
  end

  assign copy_o = !ready_o;

  a_r7_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r7_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_o |-> 32'(idx_o) < BOOT_LEN);
endmodule

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned NV_BASE    = 'hF800,
  parameter int unsigned PAGES      = 32,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned RAM_BYTES  = 224,
  parameter int unsigned BOOT_LEN   = 8,
  parameter int unsigned PROG_CYC   = 4,
  parameter int unsigned ERASE_CYC  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [1:0]  op_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic        ack_o,
  output logic [7:0]  rdata_o,
  output logic        busy_o,
  output logic        ready_o,
  output logic        err_o
);
  localparam int unsigned NV_BYTES = PAGES * PAGE_BYTES;
  localparam int unsigned NV_AW    = $clog2(NV_BYTES);
  localparam int unsigned PG_W     = $clog2(PAGES);
  localparam int unsigned OFF_W    = $clog2(PAGE_BYTES);
  localparam int unsigned RAM_AW   = $clog2(RAM_BYTES);
  localparam int unsigned BW       = $clog2(BOOT_LEN + 1);
  localparam int unsigned MAX_CYC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);

  op_e               op;
  rgn_e              rgn;
  logic [NV_AW-1:0]  nv_off;
  logic [RAM_AW-1:0] ram_idx;
  logic [7:0]        nv_rd, boot_byte;
  logic              boot_copy;
  logic [BW-1:0]     boot_idx;
  logic [NV_AW-1:0]  ptr_q;
  logic [7:0]        ram [RAM_BYTES];
  logic              acc_ok, is_wr, is_cmd, nv_wr_try, prog_en, erase_en;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;

  assign op = op_e'(op_i);

  nvm_addr_dec #(
    .NV_BASE(NV_BASE), .NV_BYTES(NV_BYTES), .RAM_BYTES(RAM_BYTES),
    .NV_AW(NV_AW), .RAM_AW(RAM_AW)
  ) u_dec (
    .addr_i(addr_i), .rgn_o(rgn), .nv_off_o(nv_off), .ram_idx_o(ram_idx)
  );

  nvm_boot_seq #(.BOOT_LEN(BOOT_LEN)) u_boot (
    .clk_i(clk_i), .rst_ni(rst_ni), .copy_o(boot_copy), .idx_o(boot_idx), .ready_o(ready_o)
  );

  assign acc_ok    = req_i && ready_o && !busy_o;
  assign is_wr     = op == OP_WR;
  assign is_cmd    = op == OP_CMD;
  assign nv_wr_try = acc_ok && is_wr && rgn == RGN_NV;
  assign prog_en   = nv_wr_try && nv_rd == ERASED_BYTE;
  assign erase_en  = acc_ok && is_cmd && wdata_i == CMD_PAGE_ERASE
                  && ram[CFG_REG_IDX][CFG_ERASE_EN];

  nvm_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prog_en_i(prog_en), .prog_addr_i(nv_off), .prog_data_i(wdata_i),
    .erase_en_i(erase_en), .erase_page_i(ptr_q[NV_AW-1:OFF_W]),
    .rd_addr_i(nv_off), .rd_data_o(nv_rd),
    .boot_addr_i(NV_AW'(boot_idx)), .boot_data_o(boot_byte)
  );

  assign tmr_load = prog_en || erase_en;
  assign tmr_val  = erase_en ? CW'(ERASE_CYC) : CW'(PROG_CYC);

  nvm_busy_tmr #(.CW(CW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .load_val_i(tmr_val), .busy_o(busy_o)
  );

  // volatile registers: boot copy and bus writes never overlap (bus blocked until ready)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
    end else if (boot_copy) begin
      ram[RAM_AW'(boot_idx)] <= boot_byte;
    end else if (acc_ok && is_wr && rgn == RGN_RAM) begin
      ram[ram_idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      ack_o   <= req_i;
      rdata_o <= '0;
      if (acc_ok && op == OP_RD) begin
        if (rgn == RGN_RAM)     rdata_o <= ram[ram_idx];
        else if (rgn == RGN_NV) rdata_o <= nv_rd;
      end
      if (acc_ok && rgn == RGN_NV && (op == OP_RD || is_wr)) ptr_q <= nv_off;
      if ((req_i && !acc_ok && (is_wr || is_cmd)) || (nv_wr_try && !prog_en))
        err_o <= 1'b1;
    end
  end

  a_r10_ack_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  a_r10_no_data_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i != 2'd0) |=> rdata_o == '0);
  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r9_busy_from_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i && ready_o));
  a_r8_no_busy_in_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !busy_o);
endmodule

// File: tb/nvm_page_ctrl_tb_top.sv
module nvm_page_ctrl_tb_top;
  localparam int BOOT_LEN  = 8;
  localparam int PROG_CYC  = 4;
  localparam int ERASE_CYC = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_i;
  logic [1:0]  op_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i;
  logic        ack_o;
  logic [7:0]  rdata_o;
  logic        busy_o, ready_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4ns clk_i = ~clk_i;

  nvm_page_ctrl #(
    .BOOT_LEN(BOOT_LEN), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o), .busy_o(busy_o),
    .ready_o(ready_o), .err_o(err_o)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one request per call, back-to-back when called consecutively
  task automatic acc(logic [1:0] op, logic [15:0] a, logic [7:0] d, logic [7:0] exp, string tag);
    req_i = 1'b1; op_i = op; addr_i = a; wdata_i = d;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk_i); end
  endtask

  task automatic do_reset(output int n);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    while (!ready_o && n < 100) begin @(negedge clk_i); n++; end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (ack_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: unexpected ack, got %0h expected none", rdata_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(rdata_o), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    req_i = 1'b0; op_i = 2'd0; addr_i = '0; wdata_i = '0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    check("R7 ready low at reset", int'(ready_o), 0);
    check("R9 busy low at reset", int'(busy_o), 0);
    check("R11 err low at reset", int'(err_o), 0);
    // R8: accesses during boot copy
    acc(2'd1, 16'h0020, 8'hAA, 8'h00, "R8 write during boot");
    acc(2'd0, 16'hF800, 8'h00, 8'h00, "R8 read during boot");
    check("R8 err after boot write", int'(err_o), 1);
    while (!ready_o) @(negedge clk_i);
    acc(2'd0, 16'h0020, 8'h00, 8'h00, "R8 boot write did not land");

    // Phase B
    do_reset(n);
    check("R7 boot length", n, BOOT_LEN);
    check("R11 err cleared by reset", int'(err_o), 0);
    acc(2'd1, 16'h0010, 8'h3C, 8'h00, "R10 write ack data");
    acc(2'd0, 16'h0010, 8'h00, 8'h3C, "R1 ram 10h");
    acc(2'd1, 16'h00DF, 8'h5A, 8'h00, "R10 write ack data");
    acc(2'd0, 16'h00DF, 8'h00, 8'h5A, "R1 ram DFh");
    acc(2'd1, 16'h00E0, 8'h77, 8'h00, "R1 unmapped write");
    acc(2'd0, 16'h00E0, 8'h00, 8'h00, "R1 unmapped read");
    acc(2'd0, 16'hF7FF, 8'h00, 8'h00, "R1 below window");
    acc(2'd3, 16'h0010, 8'h00, 8'h00, "R10 reserved op");
    acc(2'd0, 16'hF800, 8'h00, 8'hFF, "R2 first byte erased");
    acc(2'd0, 16'hFBFF, 8'h00, 8'hFF, "R2 last byte erased");

    acc(2'd1, 16'hF800, 8'h12, 8'h00, "R10 nv write ack");
    busy_len(n);
    check("R9 program busy length", n, PROG_CYC);
    acc(2'd0, 16'hF800, 8'h00, 8'h12, "R3 program landed");
    check("R3 err clear after good program", int'(err_o), 0);
    acc(2'd1, 16'hF800, 8'h34, 8'h00, "R3 rewrite attempt");
    check("R3 rewrite starts no busy", int'(busy_o), 0);
    check("R3 err after rewrite", int'(err_o), 1);
    acc(2'd0, 16'hF800, 8'h00, 8'h12, "R3 byte unchanged");

    acc(2'd1, 16'hF805, 8'h77, 8'h00, "R10 nv write ack");
    wait_idle();
    acc(2'd1, 16'hF821, 8'h99, 8'h00, "R10 nv write ack");
    wait_idle();

    // R9: back-to-back during busy
    acc(2'd1, 16'hF806, 8'h55, 8'h00, "R10 nv write ack");
    acc(2'd0, 16'hF806, 8'h00, 8'h00, "R9 read while busy");
    acc(2'd1, 16'hF807, 8'h66, 8'h00, "R9 write while busy");
    wait_idle();
    acc(2'd0, 16'hF806, 8'h00, 8'h55, "R9 first write landed");
    acc(2'd0, 16'hF807, 8'h00, 8'hFF, "R9 busy write dropped");
    check("R11 err still set", int'(err_o), 1);

    // R5: erase without enable
    acc(2'd0, 16'hF800, 8'h00, 8'h12, "R3 readback");
    acc(2'd2, 16'h0000, 8'hFE, 8'h00, "R10 cmd ack");
    check("R5 no busy without enable", int'(busy_o), 0);
    acc(2'd0, 16'hF800, 8'h00, 8'h12, "R5 page kept");

    acc(2'd1, 16'h0090, 8'h04, 8'h00, "R10 write ack data");
    acc(2'd0, 16'h0090, 8'h00, 8'h04, "R1 cfg readback");
    // R6: other command code
    acc(2'd2, 16'h0000, 8'hA5, 8'h00, "R10 cmd ack");
    check("R6 no busy on other code", int'(busy_o), 0);
    acc(2'd0, 16'hF800, 8'h00, 8'h12, "R6 page kept");

    // R4: real erase of page 0
    acc(2'd0, 16'hF805, 8'h00, 8'h77, "R4 pointer to page 0");
    acc(2'd2, 16'h0000, 8'hFE, 8'h00, "R10 cmd ack");
    busy_len(n);
    check("R9 erase busy length", n, ERASE_CYC);
    acc(2'd0, 16'hF800, 8'h00, 8'hFF, "R4 page byte 0 erased");
    acc(2'd0, 16'hF805, 8'h00, 8'hFF, "R4 page byte 5 erased");
    acc(2'd0, 16'hF81F, 8'h00, 8'hFF, "R4 page byte 31 erased");
    acc(2'd0, 16'hF821, 8'h00, 8'h99, "R4 next page kept");

    acc(2'd1, 16'hF800, 8'h12, 8'h00, "R3 reprogram after erase");
    wait_idle();
    acc(2'd1, 16'hF801, 8'hC3, 8'h00, "R10 nv write ack");
    wait_idle();

    // Phase C: boot reload
    do_reset(n);
    check("R7 boot length second", n, BOOT_LEN);
    check("R11 err cleared again", int'(err_o), 0);
    acc(2'd0, 16'h0000, 8'h00, 8'h12, "R7 copied byte 0");
    acc(2'd0, 16'h0001, 8'h00, 8'hC3, "R7 copied byte 1");
    acc(2'd0, 16'h0002, 8'h00, 8'hFF, "R7 copied erased byte");
    acc(2'd0, 16'h0008, 8'h00, 8'h00, "R7 beyond copy range");
    acc(2'd0, 16'h0090, 8'h00, 8'h00, "R5 enable cleared by reset");
    acc(2'd0, 16'hF821, 8'h00, 8'h99, "R7 array persists");

    repeat (3) @(negedge clk_i);
    check("R10 all acks seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule